// File: doc/BRIEF.md
# Grid-Based Pixel Cluster Finder

This block takes the fired pixels of one sensor module, places them in a small bitmap that mirrors a narrow slice of the pixel matrix, and groups them into clusters of touching pixels. For each cluster it reports the pixel count, the sums of the column and row coordinates, and the centroid in both directions with one fractional bit.

The hits are loaded first, one coordinate pair per clock, while the block is idle. A start pulse then begins clustering. The block picks a seed, which is the fired pixel with the lowest column and, within that column, the lowest row. The selection then grows one ring per clock through the eight surrounding cells of every selected cell, and stops when a step adds nothing. The selected pixels are read out one per clock, summed and cleared from the bitmap. A separate averaging stage then divides the sums by the count. The loop repeats until the bitmap is empty. A one-cycle completion pulse then ends the module, and the next module or event can be loaded.

Top module: `pixel_cluster_finder`

## Requirements
- R1: After reset, `busy`, `done` and `clu_valid` are low and the bitmap is empty.
- R2: While idle, each `hit_valid` cycle marks the cell at column `hit_col`, row `hit_row`. Loading the same cell more than once has the same effect as loading it once.
- R3: Clusters are reported in the order of their seed. The seed is the set cell with the smallest column, with ties broken by the smallest row.
- R4: Two fired cells belong to the same cluster when a chain of fired cells connects them, each step moving at most one column and one row (diagonal contact counts).
- R5: For each cluster, `clu_npix` is its number of cells. `clu_sum_col` and `clu_sum_row` are the sums of its column and row indices.
- R6: `clu_cen_col` equals floor(2*sum_col/npix) and `clu_cen_row` equals floor(2*sum_row/npix). The least significant bit is the half-pixel fraction.
- R7: `busy` is high from the cycle after `start` until clustering ends. `done` is a single-cycle pulse with `busy` low, raised after the final cluster's `clu_valid`. An empty bitmap gives `done` with no cluster.
- R8: `hit_valid` has no effect while `busy` is high.
- R9: Read-out cells are cleared. A second `start` with no new loads yields `done` and no clusters.
- R10: `clu_valid` is high for exactly one cycle per cluster, never in two consecutive cycles, and the number of pulses equals the number of clusters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hit_valid | input | 1 | Load one hit into the bitmap (idle only) |
| hit_col | input | $clog2(COLS) | Column of the hit |
| hit_row | input | $clog2(ROWS) | Row of the hit |
| start | input | 1 | Begin clustering the loaded bitmap |
| busy | output | 1 | Clustering in progress |
| done | output | 1 | One-cycle pulse: bitmap emptied |
| clu_valid | output | 1 | Cluster result valid |
| clu_npix | output | $clog2(COLS*ROWS+1) | Pixels in the cluster |
| clu_sum_col | output | CW+NW | Sum of column indices |
| clu_sum_row | output | RW+NW | Sum of row indices |
| clu_cen_col | output | CW+1 | Column centroid, one fractional bit |
| clu_cen_row | output | RW+1 | Row centroid, one fractional bit |

## Verification
The assertions assume the following about the inputs. `start` arrives only while the block is idle. Hit coordinates fall inside the grid. `hit_valid` is low during reset. In the stimulus, every load and start happens between runs, after `done` has been seen, and hits driven while busy come only in the test of R8. The grid is 8 by 16, so every coordinate is in range. The sweep covers directed shapes (empty, full, corners, diagonal chains, column ties) and a few hundred random maps of graded density, some of them loaded twice.

// File: rtl/cf_pkg.sv
package cf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SEED  = 3'd1,
    ST_GROW  = 3'd2,
    ST_READ  = 3'd3,
    ST_FLUSH = 3'd4
  } cf_state_e;
endpackage

// File: rtl/cf_pick_low.sv
module cf_pick_low #(
  parameter int N  = 128,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = |vec;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/cf_grid.sv
module cf_grid #(
  parameter int COLS = 8,
  parameter int ROWS = 16,
  localparam int N  = COLS * ROWS,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [IW-1:0] load_idx,
  input  logic          seed_en,
  input  logic          grow_en,
  input  logic          clr_en,
  output logic          empty,
  output logic          grow_done,
  output logic [IW-1:0] rd_idx,
  output logic          sel_last
);
  logic [N-1:0]  hit_q, hit_d, sel_q, sel_d, near, grown, rd_mask;
  logic [IW-1:0] seed_idx;
  logic          hit_any, sel_any, hit_en, sel_en;

  cf_pick_low #(.N(N), .IW(IW)) u_seed (.vec(hit_q), .idx(seed_idx), .any(hit_any));
  cf_pick_low #(.N(N), .IW(IW)) u_read (.vec(sel_q), .idx(rd_idx),   .any(sel_any));

  // cell index = column * ROWS + row; lowest index = left-most, then top-most
  always_comb begin
    near = '0;
    for (int c = 0; c < COLS; c++) begin
      for (int r = 0; r < ROWS; r++) begin
        for (int dc = -1; dc <= 1; dc++) begin
          for (int dr = -1; dr <= 1; dr++) begin
            if ((c + dc >= 0) && (c + dc < COLS) && (r + dr >= 0) && (r + dr < ROWS)) begin
              if (sel_q[(c + dc) * ROWS + (r + dr)]) near[c * ROWS + r] = 1'b1;
            end
          end
        end
      end
    end
  end

  assign grown     = sel_q | (near & hit_q);
  assign grow_done = (grown == sel_q);
  assign empty     = !hit_any;
  assign rd_mask   = N'(1) << rd_idx;
  assign sel_last  = sel_any && ((sel_q & ~rd_mask) == '0);
  assign hit_en    = load_en | clr_en;
  assign sel_en    = seed_en | grow_en | clr_en;

  always_comb begin
    hit_d = hit_q;
    sel_d = sel_q;
    if (load_en) hit_d[load_idx] = 1'b1;
    if (seed_en) sel_d = N'(1) << seed_idx;
    if (grow_en) sel_d = grown;
    if (clr_en) begin
      hit_d = hit_d & ~rd_mask;
      sel_d = sel_d & ~rd_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= '0;
      sel_q <= '0;
    end else begin
      if (hit_en) hit_q <= hit_d;
      if (sel_en) sel_q <= sel_d;
    end
  end

  // R4: the selection only ever covers fired cells
  a_r4_sel_in_hits: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_q & ~hit_q) == '0));

  // R8: without a load in the previous cycle no cell becomes set
  a_r8_no_gain_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load_en) |-> ((hit_q & ~$past(hit_q)) == '0));
endmodule

// File: rtl/cf_avg.sv
module cf_avg #(
  parameter int COLS = 8,
  parameter int ROWS = 16,
  localparam int N   = COLS * ROWS,
  localparam int CW  = $clog2(COLS),
  localparam int RW  = $clog2(ROWS),
  localparam int NW  = $clog2(N + 1),
  localparam int SCW = CW + NW,
  localparam int SRW = RW + NW,
  localparam int SCX = SCW + 1,
  localparam int SRX = SRW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc_clr,
  input  logic           acc_en,
  input  logic           acc_fin,
  input  logic [CW-1:0]  pix_col,
  input  logic [RW-1:0]  pix_row,
  output logic           clu_valid,
  output logic [NW-1:0]  npix,
  output logic [SCW-1:0] sum_col,
  output logic [SRW-1:0] sum_row,
  output logic [CW:0]    cen_col,
  output logic [RW:0]    cen_row
);
  logic [SCW-1:0] acc_c_q, acc_c_d, s1_c_q;
  logic [SRW-1:0] acc_r_q, acc_r_d, s1_r_q;
  logic [NW-1:0]  acc_n_q, acc_n_d, s1_n_q;
  logic           s1_v_q, s1_en, acc_ld;
  logic [CW:0]    cen_c_d;
  logic [RW:0]    cen_r_d;

  // stage 1: running sums of the pixels being read out
  always_comb begin
    acc_c_d = acc_c_q + SCW'(pix_col);
    acc_r_d = acc_r_q + SRW'(pix_row);
    acc_n_d = acc_n_q + NW'(1);
    if (acc_clr) begin
      acc_c_d = '0;
      acc_r_d = '0;
      acc_n_d = '0;
    end
  end

  assign acc_ld = acc_clr | acc_en;
  assign s1_en  = acc_en & acc_fin;

  // stage 2: averaging, two times the mean truncated
  always_comb begin
    cen_c_d = '0;
    cen_r_d = '0;
    if (s1_n_q != '0) begin
      cen_c_d = (CW + 1)'({s1_c_q, 1'b0} / SCX'(s1_n_q));
      cen_r_d = (RW + 1)'({s1_r_q, 1'b0} / SRX'(s1_n_q));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_c_q   <= '0;
      acc_r_q   <= '0;
      acc_n_q   <= '0;
      s1_c_q    <= '0;
      s1_r_q    <= '0;
      s1_n_q    <= '0;
      s1_v_q    <= 1'b0;
      clu_valid <= 1'b0;
      npix      <= '0;
      sum_col   <= '0;
      sum_row   <= '0;
      cen_col   <= '0;
      cen_row   <= '0;
    end else begin
      s1_v_q    <= s1_en;
      clu_valid <= s1_v_q;
      if (acc_ld) begin
        acc_c_q <= acc_c_d;
        acc_r_q <= acc_r_d;
        acc_n_q <= acc_n_d;
      end
      if (s1_en) begin
        s1_c_q <= acc_c_d;
        s1_r_q <= acc_r_d;
        s1_n_q <= acc_n_d;
      end
      if (s1_v_q) begin
        npix    <= s1_n_q;
        sum_col <= s1_c_q;
        sum_row <= s1_r_q;
        cen_col <= cen_c_d;
        cen_row <= cen_r_d;
      end
    end
  end

  // R5: a reported cluster holds at least one pixel
  a_r5_npix_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    clu_valid |-> (npix != '0));

  // R6: centroids stay inside the grid in half-pixel units
  a_r6_cen_bound: assert property (@(posedge clk) disable iff (!rst_n)
    clu_valid |-> ((int'(cen_col) <= 2 * (COLS - 1)) && (int'(cen_row) <= 2 * (ROWS - 1))));
endmodule

// File: rtl/pixel_cluster_finder.sv
module pixel_cluster_finder #(
  parameter int COLS = 8,
  parameter int ROWS = 16,
  localparam int N   = COLS * ROWS,
  localparam int IW  = $clog2(N),
  localparam int CW  = $clog2(COLS),
  localparam int RW  = $clog2(ROWS),
  localparam int NW  = $clog2(N + 1),
  localparam int SCW = CW + NW,
  localparam int SRW = RW + NW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hit_valid,
  input  logic [CW-1:0]  hit_col,
  input  logic [RW-1:0]  hit_row,
  input  logic           start,
  output logic           busy,
  output logic           done,
  output logic           clu_valid,
  output logic [NW-1:0]  clu_npix,
  output logic [SCW-1:0] clu_sum_col,
  output logic [SRW-1:0] clu_sum_row,
  output logic [CW:0]    clu_cen_col,
  output logic [RW:0]    clu_cen_row
);
  import cf_pkg::*;

  logic          rst_s1_q, rst_i_n;
  cf_state_e     state_q, state_d;
  logic          done_q;
  logic          load_en, seed_en, grow_en, clr_en, acc_fin;
  logic          empty, grow_done, sel_last;
  logic [IW-1:0] load_idx, rd_idx;
  logic [CW-1:0] pix_col;
  logic [RW-1:0] pix_row;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_i_n  <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_i_n  <= rst_s1_q;
    end
  end

  assign load_idx = IW'(hit_col) * IW'(ROWS) + IW'(hit_row);
  assign pix_col  = CW'(rd_idx / IW'(ROWS));
  assign pix_row  = RW'(rd_idx % IW'(ROWS));

  always_comb begin
    state_d = state_q;
    load_en = 1'b0;
    seed_en = 1'b0;
    grow_en = 1'b0;
    clr_en  = 1'b0;
    acc_fin = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        load_en = hit_valid;
        if (start) state_d = ST_SEED;
      end
      ST_SEED: begin
        if (empty) state_d = ST_FLUSH;
        else begin
          seed_en = 1'b1;
          state_d = ST_GROW;
        end
      end
      ST_GROW: begin
        grow_en = 1'b1;
        if (grow_done) state_d = ST_READ;
      end
      ST_READ: begin
        clr_en  = 1'b1;
        acc_fin = sel_last;
        if (sel_last) state_d = ST_SEED;
      end
      ST_FLUSH: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_FLUSH);
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;

  cf_grid #(.COLS(COLS), .ROWS(ROWS)) u_grid (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .load_en   (load_en),
    .load_idx  (load_idx),
    .seed_en   (seed_en),
    .grow_en   (grow_en),
    .clr_en    (clr_en),
    .empty     (empty),
    .grow_done (grow_done),
    .rd_idx    (rd_idx),
    .sel_last  (sel_last)
  );

  cf_avg #(.COLS(COLS), .ROWS(ROWS)) u_avg (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .acc_clr   (seed_en),
    .acc_en    (clr_en),
    .acc_fin   (acc_fin),
    .pix_col   (pix_col),
    .pix_row   (pix_row),
    .clu_valid (clu_valid),
    .npix      (clu_npix),
    .sum_col   (clu_sum_col),
    .sum_row   (clu_sum_row),
    .cen_col   (clu_cen_col),
    .cen_row   (clu_cen_row)
  );

  // R7: completion pulse lasts one cycle and comes with the block idle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |=> !done);
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |-> !busy);

  // R10: result strobes never come back to back
  a_r10_valid_gap: assert property (@(posedge clk) disable iff (!rst_i_n)
    clu_valid |=> !clu_valid);

  // R7: results only appear while clustering or on the way out
  a_r7_valid_busy: assert property (@(posedge clk) disable iff (!rst_i_n)
    clu_valid |-> busy);
endmodule

// File: tb/tb_pixel_cluster_finder.sv
`timescale 1ns/1ps
module tb_pixel_cluster_finder;
  localparam int COLS = 8;
  localparam int ROWS = 16;
  localparam int N    = COLS * ROWS;
  localparam int CW   = $clog2(COLS);
  localparam int RW   = $clog2(ROWS);
  localparam int NW   = $clog2(N + 1);

  logic clk, rst_n, hit_valid, start;
  logic [CW-1:0] hit_col;
  logic [RW-1:0] hit_row;
  logic busy, done, clu_valid;
  logic [NW-1:0]    clu_npix;
  logic [CW+NW-1:0] clu_sum_col;
  logic [RW+NW-1:0] clu_sum_row;
  logic [CW:0]      clu_cen_col;
  logic [RW:0]      clu_cen_row;

  int checks = 0;
  int fails  = 0;
  int exp_cnt;
  int exp_n[N], exp_sc[N], exp_sr[N];

  pixel_cluster_finder #(.COLS(COLS), .ROWS(ROWS)) dut (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_col(hit_col),
    .hit_row(hit_row), .start(start), .busy(busy), .done(done),
    .clu_valid(clu_valid), .clu_npix(clu_npix), .clu_sum_col(clu_sum_col),
    .clu_sum_row(clu_sum_row), .clu_cen_col(clu_cen_col), .clu_cen_row(clu_cen_row)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // reference clustering: cell index = col*ROWS + row
  task automatic build_expected(input logic [N-1:0] m);
    logic [N-1:0] w, mark;
    bit grew;
    w = m;
    exp_cnt = 0;
    while (w != '0) begin
      mark = '0;
      for (int i = N - 1; i >= 0; i--) if (w[i]) mark = N'(1) << i;
      grew = 1'b1;
      while (grew) begin
        grew = 1'b0;
        for (int j = 0; j < N; j++) begin
          if (w[j] && !mark[j]) begin
            for (int k = 0; k < N; k++) begin
              if (mark[k] && (j / ROWS - k / ROWS) <= 1 && (k / ROWS - j / ROWS) <= 1 &&
                  (j % ROWS - k % ROWS) <= 1 && (k % ROWS - j % ROWS) <= 1) begin
                if (!mark[j]) grew = 1'b1;
                mark[j] = 1'b1;
              end
            end
          end
        end
      end
      exp_n[exp_cnt] = 0; exp_sc[exp_cnt] = 0; exp_sr[exp_cnt] = 0;
      for (int j = 0; j < N; j++) begin
        if (mark[j]) begin
          exp_n[exp_cnt]++;
          exp_sc[exp_cnt] += j / ROWS;
          exp_sr[exp_cnt] += j % ROWS;
        end
      end
      w = w & ~mark;
      exp_cnt++;
    end
  endtask

  task automatic load_map(input logic [N-1:0] m, input bit dup);
    for (int rep = 0; rep < (dup ? 2 : 1); rep++) begin
      for (int i = 0; i < N; i++) begin
        if (m[i]) begin
          @(negedge clk);
          hit_valid = 1'b1;
          hit_col   = CW'(i / ROWS);
          hit_row   = RW'(i % ROWS);
        end
      end
    end
    @(negedge clk);
    hit_valid = 1'b0;
  endtask

  task automatic run_check(input bit inject, input string tag);
    int got;
    bit fin;
    got = 0;
    fin = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R7 busy after start", int'(busy), 1);
    if (inject) begin
      hit_valid = 1'b1;
      hit_col   = CW'(5);
      hit_row   = RW'(9);
    end
    while (!fin) begin
      @(negedge clk);
      if (clu_valid) begin
        if (got < exp_cnt) begin
          chk(int'(clu_npix) == exp_n[got], {"R5 npix ", tag}, int'(clu_npix), exp_n[got]);
          chk(int'(clu_sum_col) == exp_sc[got], {"R5 sum_col R3 order ", tag}, int'(clu_sum_col), exp_sc[got]);
          chk(int'(clu_sum_row) == exp_sr[got], {"R5 sum_row R4 link ", tag}, int'(clu_sum_row), exp_sr[got]);
          chk(int'(clu_cen_col) == (2 * exp_sc[got]) / exp_n[got], {"R6 cen_col ", tag},
              int'(clu_cen_col), (2 * exp_sc[got]) / exp_n[got]);
          chk(int'(clu_cen_row) == (2 * exp_sr[got]) / exp_n[got], {"R6 cen_row ", tag},
              int'(clu_cen_row), (2 * exp_sr[got]) / exp_n[got]);
        end
        got++;
      end
      if (done) begin
        fin = 1'b1;
        chk(busy == 1'b0, "R7 idle at done", int'(busy), 0);
      end
    end
    hit_valid = 1'b0;
    chk(got == exp_cnt, {"R10 cluster count ", tag}, got, exp_cnt);
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", int'(done), 0);
  endtask

  task automatic event_run(input logic [N-1:0] m, input bit dup, input string tag);
    build_expected(m);
    load_map(m, dup);
    run_check(1'b0, tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] m;
    int dens;
    rst_n = 1'b0; hit_valid = 1'b0; start = 1'b0; hit_col = '0; hit_row = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(clu_valid == 1'b0, "R1 clu_valid", int'(clu_valid), 0);

    // R1, R7: empty bitmap after reset finishes with no cluster
    event_run('0, 1'b0, "R7 empty");

    // R3, R5: single pixels at the four corners
    event_run(N'(1), 1'b0, "corner c0r0");
    event_run(N'(1) << (ROWS - 1), 1'b0, "corner c0r15");
    event_run(N'(1) << ((COLS - 1) * ROWS), 1'b0, "corner c7r0");
    event_run(N'(1) << (N - 1), 1'b0, "corner c7r15");

    // R4: diagonal chain is one cluster
    m = '0;
    for (int i = 0; i < COLS; i++) m[i * ROWS + i] = 1'b1;
    event_run(m, 1'b0, "R4 diagonal");

    // R3: low column wins over low row
    m = '0;
    m[1 * ROWS + 15] = 1'b1;
    m[3 * ROWS + 0]  = 1'b1;
    m[3 * ROWS + 1]  = 1'b1;
    event_run(m, 1'b0, "R3 column first");

    // R4: one empty column separates two bars
    m = '0;
    for (int r = 0; r < ROWS; r++) begin
      m[2 * ROWS + r] = 1'b1;
      m[4 * ROWS + r] = 1'b1;
    end
    event_run(m, 1'b0, "R4 gap");

    // R5, R6: full grid
    event_run('1, 1'b0, "R5 full");

    // R2: duplicate loads count once
    m = '0;
    m[0] = 1'b1; m[1] = 1'b1; m[ROWS + 2] = 1'b1;
    event_run(m, 1'b1, "R2 duplicates");

    // R8: hits during busy ignored, R9: bitmap left empty
    build_expected(N'(1));
    load_map(N'(1), 1'b0);
    run_check(1'b1, "R8 locked");
    build_expected('0);
    run_check(1'b0, "R9 cleared");

    // sweep over graded densities
    for (int ev = 0; ev < 300; ev++) begin
      dens = 1 + (ev % 8);
      for (int i = 0; i < N; i++) m[i] = ($urandom_range(15) < dens);
      event_run(m, (ev % 7) == 0, "sweep");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule